// File: doc/BRIEF.md
# Dual-Port Same-Address Collision Arbiter

This block sits beside a two-port memory array and settles the case where both ports are selected and point at the same word. Each port brings an active-low select, an address and a one-cycle completion strobe. When the two accesses collide, one port is granted the location. The other port sees its active-low busy flag driven low and must hold its operation until the flag returns high. The grant outputs are meant to gate the array's read and write enables for each port.

Arrival order is judged in clock cycles. A port's access is "new" in a cycle when its select has just gone low, or when its address differs from the previous cycle while it is selected. When a collision first appears, the port whose access was already standing wins. If the addresses already agreed, that is the port that was selected earlier. If both were already selected, that is the port whose address was there first. A same-cycle tie goes to the left port. Ownership is kept until the owner signals completion, at which point the waiting port takes the location over.

Top module: `dpArbiter`

## Requirements
- R1: A collision exists only while both selects are low (active) and both addresses are equal. Without a collision both busy outputs stay high, and every selected port has its grant high.
- R2: During a collision exactly one busy output is low, and only the other port's grant is high.
- R3: When the addresses were already equal and one port's select goes low after the other's, the port that was selected first wins.
- R4: When both ports were already selected and one port moves its address onto the other's, the port whose address was there first wins.
- R5: A port whose busy is low has its grant low, and its completion strobe has no effect on ownership.
- R6: A completion strobe from the owning port during a collision that persists hands the location over from the next cycle. The waiting port's busy goes high and its grant goes high, and the former owner's busy goes low.
- R7: When both accesses become new in the same cycle and collide, the left port wins.
- R8: Once ownership is held, the collision ends in the same cycle if the waiting port changes its address or deselects. Its busy then returns high.
- R9: After reset both busy outputs are high and both grants are low until a port is selected. The two busy outputs are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| selLeftN | input | 1 | Left port select, active low |
| selRightN | input | 1 | Right port select, active low |
| addrLeft | input | ADDR_W | Left port word address |
| addrRight | input | ADDR_W | Right port word address |
| doneLeft | input | 1 | Left port completion strobe, one cycle, active high |
| doneRight | input | 1 | Right port completion strobe, one cycle, active high |
| busyLeftN | output | 1 | Left port inhibited, active low |
| busyRightN | output | 1 | Right port inhibited, active low |
| grantLeft | output | 1 | Left port may touch the array |
| grantRight | output | 1 | Right port may touch the array |

## Verification
The bench builds the arbiter with ADDR_W = 6. With that width, moving either port's address onto or off the other's takes only a few values, and the top word 63 can serve as a collision address. Ownership is carried through both arbitration orders, the tie, a handover and back, a loser's release by address change and an ignored strobe from the waiting port.

// File: rtl/dpArbPkg.sv
package dpArbPkg;

  // Per-cycle events seen by the datapath, consumed by the control
  typedef struct packed {
    logic conflict;  // both selected, same address
    logic freshL;    // left access new this cycle
    logic freshR;    // right access new this cycle
  } arbEvt_t;

  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

endpackage

// File: rtl/dpArbDatapath.sv
module dpArbDatapath
  import dpArbPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLeftN,
  input  logic              selRightN,
  input  logic [ADDR_W-1:0] addrLeft,
  input  logic [ADDR_W-1:0] addrRight,
  output arbEvt_t           evt
);

  logic              prevSelLN, prevSelRN;
  logic [ADDR_W-1:0] prevAddrL, prevAddrR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSelLN <= 1'b1;
      prevSelRN <= 1'b1;
      prevAddrL <= '0;
      prevAddrR <= '0;
    end else begin
      prevSelLN <= selLeftN;
      prevSelRN <= selRightN;
      prevAddrL <= addrLeft;
      prevAddrR <= addrRight;
    end
  end

  always_comb begin
    evt.conflict = !selLeftN && !selRightN && (addrLeft == addrRight);
    evt.freshL   = !selLeftN  && (prevSelLN || (addrLeft  != prevAddrL));
    evt.freshR   = !selRightN && (prevSelRN || (addrRight != prevAddrR));
  end

endmodule

// File: rtl/dpArbControl.sv
module dpArbControl
  import dpArbPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  arbEvt_t evt,
  input  logic    selLeftN,
  input  logic    selRightN,
  input  logic    doneLeft,
  input  logic    doneRight,
  output logic    busyLeftN,
  output logic    busyRightN,
  output logic    grantLeft,
  output logic    grantRight
);

  owner_e owner, ownerNxt;
  logic   leftLoses, rightLoses;

  always_comb begin
    leftLoses  = 1'b0;
    rightLoses = 1'b0;
    if (evt.conflict) begin
      case (owner)
        OWN_LEFT:  rightLoses = 1'b1;
        OWN_RIGHT: leftLoses  = 1'b1;
        default: begin
          if (evt.freshL && !evt.freshR) leftLoses  = 1'b1;
          else                           rightLoses = 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ownerNxt = owner;
    if (!evt.conflict) begin
      ownerNxt = OWN_NONE;
    end else begin
      case (owner)
        OWN_LEFT:  ownerNxt = doneLeft  ? OWN_RIGHT : OWN_LEFT;
        OWN_RIGHT: ownerNxt = doneRight ? OWN_LEFT  : OWN_RIGHT;
        default:   ownerNxt = leftLoses ? OWN_RIGHT : OWN_LEFT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) owner <= OWN_NONE;
    else       owner <= ownerNxt;
  end

  assign busyLeftN  = !leftLoses;
  assign busyRightN = !rightLoses;
  assign grantLeft  = !selLeftN  && !leftLoses;
  assign grantRight = !selRightN && !rightLoses;

  // R9
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyLeftN && !busyRightN));

  // R2
  one_loser_chk: assert property (@(posedge clk) disable iff (!rstN)
    evt.conflict |-> (busyLeftN != busyRightN));

  // R1
  no_conflict_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evt.conflict |-> (busyLeftN && busyRightN));

  // R6
  handoff_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_LEFT && evt.conflict && doneLeft) |=> (!evt.conflict || !busyLeftN));

  // R6
  handoff_right_chk: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_RIGHT && evt.conflict && doneRight) |=> (!evt.conflict || !busyRightN));

  // R7
  tie_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_NONE && evt.conflict && evt.freshL && evt.freshR) |-> !busyRightN);

  // R5
  loser_strobe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (owner == OWN_LEFT && evt.conflict && doneRight && !doneLeft) |=> (!evt.conflict || !busyRightN));

endmodule

// File: rtl/dpArbiter.sv
module dpArbiter
  import dpArbPkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selLeftN,
  input  logic              selRightN,
  input  logic [ADDR_W-1:0] addrLeft,
  input  logic [ADDR_W-1:0] addrRight,
  input  logic              doneLeft,
  input  logic              doneRight,
  output logic              busyLeftN,
  output logic              busyRightN,
  output logic              grantLeft,
  output logic              grantRight
);

  arbEvt_t evt;

  dpArbDatapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .selLeftN  (selLeftN),
    .selRightN (selRightN),
    .addrLeft  (addrLeft),
    .addrRight (addrRight),
    .evt       (evt)
  );

  dpArbControl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .evt        (evt),
    .selLeftN   (selLeftN),
    .selRightN  (selRightN),
    .doneLeft   (doneLeft),
    .doneRight  (doneRight),
    .busyLeftN  (busyLeftN),
    .busyRightN (busyRightN),
    .grantLeft  (grantLeft),
    .grantRight (grantRight)
  );

endmodule

// File: tb/dpArbiter_tb.sv
module dpArbiter_tb;

  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic selLeftN = 1'b1, selRightN = 1'b1;
  logic [ADDR_W-1:0] addrLeft = '0, addrRight = '0;
  logic doneLeft = 1'b0, doneRight = 1'b0;
  logic busyLeftN, busyRightN, grantLeft, grantRight;

  always #10 clk = ~clk;  // 50 MHz

  dpArbiter #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN),
    .selLeftN(selLeftN), .selRightN(selRightN),
    .addrLeft(addrLeft), .addrRight(addrRight),
    .doneLeft(doneLeft), .doneRight(doneRight),
    .busyLeftN(busyLeftN), .busyRightN(busyRightN),
    .grantLeft(grantLeft), .grantRight(grantRight)
  );

  typedef struct {
    string    req;
    logic [3:0] exp;  // {busyLeftN, busyRightN, grantLeft, grantRight}
  } expItem_t;

  expItem_t scoreQ[$];
  int applied = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // Driver: apply one cycle of stimulus and queue what it must produce
  task automatic applyVec(input logic sl, input logic sr,
                          input int al, input int ar,
                          input logic dl, input logic dr,
                          input logic [3:0] exp, input string req);
    expItem_t it;
    @(negedge clk);
    selLeftN  = sl;
    selRightN = sr;
    addrLeft  = ADDR_W'(al);
    addrRight = ADDR_W'(ar);
    doneLeft  = dl;
    doneRight = dr;
    it.req = req;
    it.exp = exp;
    scoreQ.push_back(it);
  endtask

  // Monitor: sample midway between negedge and posedge
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        expItem_t it;
        logic [3:0] act;
        it  = scoreQ.pop_front();
        act = {busyLeftN, busyRightN, grantLeft, grantRight};
        applied++;
        if (act !== it.exp) begin
          miscompares++;
          $display("FAIL %s: {busyL,busyR,grantL,grantR} actual %b expected %b",
                   it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9 reset state, nothing selected
    applyVec(1, 1, 5, 5, 0, 0, 4'b1100, "R9");
    // R1 one port selected, no collision
    applyVec(0, 1, 5, 5, 0, 0, 4'b1110, "R1");
    // R3 addresses equal first, left selected earlier wins
    applyVec(0, 0, 5, 5, 0, 0, 4'b1010, "R3");
    applyVec(0, 0, 5, 5, 0, 0, 4'b1010, "R2");
    // R6 owner completes, handover next cycle
    applyVec(0, 0, 5, 5, 1, 0, 4'b1010, "R6");
    applyVec(0, 0, 5, 5, 0, 0, 4'b0101, "R6");
    applyVec(0, 0, 5, 5, 0, 1, 4'b0101, "R6");
    // R1 right deselects, collision gone
    applyVec(0, 1, 5, 5, 0, 0, 4'b1110, "R1");
    applyVec(1, 1, 5, 5, 0, 0, 4'b1100, "R9");
    // R3 right selected first wins
    applyVec(1, 0, 7, 7, 0, 0, 4'b1101, "R1");
    applyVec(0, 0, 7, 7, 0, 0, 4'b0101, "R3");
    // R8 loser moves its address, released at once
    applyVec(0, 0, 8, 7, 0, 0, 4'b1111, "R8");
    // R4 both selected, left moves onto right's address
    applyVec(0, 0, 8, 9, 0, 0, 4'b1111, "R1");
    applyVec(0, 0, 9, 9, 0, 0, 4'b0101, "R4");
    applyVec(0, 0, 9, 3, 0, 0, 4'b1111, "R8");
    // R4 right moves onto left's address, left was there first
    applyVec(0, 0, 9, 9, 0, 0, 4'b1010, "R4");
    applyVec(1, 0, 9, 9, 0, 0, 4'b1101, "R1");
    applyVec(1, 1, 9, 9, 0, 0, 4'b1100, "R9");
    // R7 same-cycle arrival goes to left
    applyVec(0, 0, 12, 12, 0, 0, 4'b1010, "R7");
    applyVec(0, 0, 20, 20, 0, 0, 4'b1010, "R2");
    // R5 loser's strobe ignored, its grant stays low
    applyVec(0, 0, 20, 20, 0, 1, 4'b1010, "R5");
    applyVec(0, 0, 20, 20, 0, 0, 4'b1010, "R5");
    applyVec(1, 1, 20, 20, 0, 0, 4'b1100, "R9");
    // R7 tie at the top word
    applyVec(0, 0, 63, 63, 0, 0, 4'b1010, "R7");
    applyVec(1, 1, 63, 63, 0, 0, 4'b1100, "R9");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
    $finish;
  end

endmodule